// File: doc/BRIEF.md
# Address Quadrant Context Qualifier

This block turns a 64-bit effective address into the translation context that a later table walk needs. The two most significant address bits select one of four quadrants. Depending on whether the processor runs in hypervisor mode, each quadrant yields a partition identifier and a process identifier. Each of these is either taken from the current identifier registers or forced to zero. Some quadrants are illegal for a guest, and addresses with nonzero bits in the reserved field just below the quadrant bits are rejected. In both cases a segment fault is raised instead of a context.

A hypervisor access with relocation disabled needs no tables. For such an access the block directly forms the real address from the effective address and a relocation-base register. It also reports full access rights and the smallest page size. A fault is classed as an instruction fault or a data fault from the access type. For data faults the offending address is kept on a dedicated output.

A request is taken on a one-cycle strobe. The outcome appears on registered outputs together with a single-cycle done pulse, two cycles after the strobe. A new request can be issued every cycle.

Top module: `ctx_qualifier`

## Requirements
- R1: When `req_valid` is high in cycle c, `done` is high in cycle c+2 for exactly that one cycle. Strobes in consecutive cycles each produce their own done pulse, in order.
- R2: Outside hypervisor real mode, if any of address bits 61 down to 52 (little-endian numbering) is set, the result is a segment fault with `ctx_ok` low, whatever the quadrant.
- R3: In hypervisor mode with relocation, the quadrant is `ea[63:62]`. Quadrant 0 gives partition 0 with the current process ID. Quadrant 1 gives both current IDs. Quadrant 2 gives the current partition with process 0. Quadrant 3 gives partition 0 and process 0.
- R4: In guest mode (`hv_mode` low), quadrant 3 gives the current partition with process 0, and quadrant 0 gives both current IDs.
- R5: In guest mode, quadrants 1 and 2 produce a segment fault.
- R6: The access type is encoded as 00 load, 01 store, 10 instruction fetch, with 11 handled as a data access. A fault on a fetch raises `seg_fault_inst`. A fault on any other type raises `seg_fault_data` and loads the effective address into `fault_addr`. `fault_addr` changes on no other result.
- R7: In hypervisor real mode (`hv_mode` and `real_mode` both high), `real_ok` is set. `real_addr` is the address with bits 63:60 cleared, ORed with `reloc_base` when bit 63 of the address is clear. No segment or quadrant check applies.
- R8: A hypervisor real-mode result has `perm` = 3'b111 (bit 2 read, bit 1 write, bit 0 execute) and `page_bits` = 12. For every other result these are zero, as are the IDs when `ctx_ok` is low and `real_addr` when `real_ok` is low.
- R9: In guest mode, `real_mode` has no effect: the address goes through the same quadrant qualification as a relocated guest access.
- R10: Between results all outputs hold their values and `done` stays low. Input changes without a strobe have no effect.
- R11: A synchronous active-high reset clears `done`, every result output, both fault flags and `fault_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_ea | input | 64 | Effective address |
| req_kind | input | 2 | Access type: 00 load, 01 store, 10 fetch |
| hv_mode | input | 1 | Hypervisor mode |
| real_mode | input | 1 | Relocation disabled |
| cur_part_id | input | 32 | Current partition ID register |
| cur_proc_id | input | 32 | Current process ID register |
| reloc_base | input | 64 | Relocation-base register for hypervisor real mode |
| done | output | 1 | Result valid pulse |
| ctx_ok | output | 1 | A translation context was produced |
| real_ok | output | 1 | A real address was produced |
| seg_fault_inst | output | 1 | Instruction segment fault |
| seg_fault_data | output | 1 | Data segment fault |
| part_id | output | 32 | Qualified partition ID |
| proc_id | output | 32 | Qualified process ID |
| real_addr | output | 64 | Real address in hypervisor real mode |
| perm | output | 3 | Read, write, execute rights |
| page_bits | output | 7 | Log2 of the page size |
| fault_addr | output | 64 | Address of the last data segment fault |

## Verification
Every quadrant is driven under both modes with distinct nonzero ID values, so a swapped or wrongly zeroed ID shows up as a mismatch. Single reserved bits are set at both ends of the checked field, in both modes and with each access type, to separate a missing range check from a wrong fault class. Real mode is tried with bit 63 set and clear and with reserved bits set, and in guest mode with real mode set. Together these show that the bypass applies only to hypervisor real mode. Back-to-back strobes, idle stretches with changing inputs and a mid-run reset exercise the pipeline timing and the hold behaviour.

// File: rtl/ctx_qual_pkg.sv
package ctx_qual_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    QD_ZERO  = 2'b00,
    QD_ONE   = 2'b01,
    QD_TWO   = 2'b10,
    QD_THREE = 2'b11
  } quadrant_e;

  typedef struct packed {
    logic ctx_ok;
    logic real_ok;
    logic seg_inst;
    logic seg_data;
  } outcome_t;

  localparam logic [2:0] PERM_ALL  = 3'b111;
  localparam logic [2:0] PERM_NONE = 3'b000;
endpackage

// File: rtl/ctx_req_stage.sv
module ctx_req_stage #(
  parameter int EA_W = 64,
  parameter int ID_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [EA_W-1:0] in_ea,
  input  logic [1:0]      in_kind,
  input  logic            in_hv,
  input  logic            in_real,
  input  logic [ID_W-1:0] in_part,
  input  logic [ID_W-1:0] in_proc,
  input  logic [EA_W-1:0] in_reloc,
  output logic            s_valid,
  output logic [EA_W-1:0] s_ea,
  output logic            s_fetch,
  output logic            s_hv,
  output logic            s_real,
  output logic [ID_W-1:0] s_part,
  output logic [ID_W-1:0] s_proc,
  output logic [EA_W-1:0] s_reloc
);
  import ctx_qual_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_valid <= 1'b0;
      s_ea    <= '0;
      s_fetch <= 1'b0;
      s_hv    <= 1'b0;
      s_real  <= 1'b0;
      s_part  <= '0;
      s_proc  <= '0;
      s_reloc <= '0;
    end else begin
      s_valid <= in_valid;
      if (in_valid) begin
        s_ea    <= in_ea;
        s_fetch <= (acc_kind_e'(in_kind) == ACC_FETCH);
        s_hv    <= in_hv;
        s_real  <= in_real;
        s_part  <= in_part;
        s_proc  <= in_proc;
        s_reloc <= in_reloc;
      end
    end
  end
endmodule

// File: rtl/ctx_quadrant_map.sv
module ctx_quadrant_map #(
  parameter int ID_W     = 32,
  parameter int SEG_BITS = 10
) (
  input  logic [1:0]          quad,
  input  logic [SEG_BITS-1:0] rsvd_field,
  input  logic                hv,
  input  logic [ID_W-1:0]     cur_part,
  input  logic [ID_W-1:0]     cur_proc,
  output logic                fault,
  output logic [ID_W-1:0]     part_out,
  output logic [ID_W-1:0]     proc_out
);
  import ctx_qual_pkg::*;

  logic use_part, use_proc, illegal;

  always_comb begin
    use_part = 1'b0;
    use_proc = 1'b0;
    illegal  = 1'b0;
    if (hv) begin
      unique case (quadrant_e'(quad))
        QD_ZERO:  use_proc = 1'b1;
        QD_ONE:   begin use_part = 1'b1; use_proc = 1'b1; end
        QD_TWO:   use_part = 1'b1;
        QD_THREE: ;
      endcase
    end else begin
      unique case (quadrant_e'(quad))
        QD_ZERO:  begin use_part = 1'b1; use_proc = 1'b1; end
        QD_THREE: use_part = 1'b1;
        default:  illegal = 1'b1;
      endcase
    end
  end

  assign fault    = illegal | (|rsvd_field);
  assign part_out = use_part ? cur_part : '0;
  assign proc_out = use_proc ? cur_proc : '0;
endmodule

// File: rtl/ctx_real_xlate.sv
module ctx_real_xlate #(
  parameter int EA_W    = 64,
  parameter int TOP_CLR = 4
) (
  input  logic [EA_W-1:0] ea,
  input  logic [EA_W-1:0] reloc,
  output logic [EA_W-1:0] raddr
);
  localparam int KEEP_W = EA_W - TOP_CLR;

  logic [EA_W-1:0] kept;

  generate
    for (genvar b = 0; b < EA_W; b++) begin : g_bit
      if (b < KEEP_W) begin : g_keep
        assign kept[b] = ea[b];
      end else begin : g_clear
        assign kept[b] = 1'b0;
      end
    end
  endgenerate

  assign raddr = ea[EA_W-1] ? kept : (kept | reloc);
endmodule

// File: rtl/ctx_qualifier.sv
module ctx_qualifier #(
  parameter int EA_W          = 64,
  parameter int ID_W          = 32,
  parameter int PG_W          = 7,
  parameter int MIN_PAGE_BITS = 12,
  parameter int TOP_CLR       = 4,
  parameter int SEG_BITS      = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [EA_W-1:0] req_ea,
  input  logic [1:0]      req_kind,
  input  logic            hv_mode,
  input  logic            real_mode,
  input  logic [ID_W-1:0] cur_part_id,
  input  logic [ID_W-1:0] cur_proc_id,
  input  logic [EA_W-1:0] reloc_base,
  output logic            done,
  output logic            ctx_ok,
  output logic            real_ok,
  output logic            seg_fault_inst,
  output logic            seg_fault_data,
  output logic [ID_W-1:0] part_id,
  output logic [ID_W-1:0] proc_id,
  output logic [EA_W-1:0] real_addr,
  output logic [2:0]      perm,
  output logic [PG_W-1:0] page_bits,
  output logic [EA_W-1:0] fault_addr
);
  import ctx_qual_pkg::*;

  localparam int QUAD_HI = EA_W - 1;
  localparam int RSVD_HI = EA_W - 3;
  localparam logic [PG_W-1:0] MIN_PG = PG_W'(MIN_PAGE_BITS);

  logic            s_valid, s_fetch, s_hv, s_real;
  logic [EA_W-1:0] s_ea, s_reloc;
  logic [ID_W-1:0] s_part, s_proc;

  ctx_req_stage #(.EA_W(EA_W), .ID_W(ID_W)) u_stage (
    .clk(clk), .rst(rst),
    .in_valid(req_valid), .in_ea(req_ea), .in_kind(req_kind),
    .in_hv(hv_mode), .in_real(real_mode),
    .in_part(cur_part_id), .in_proc(cur_proc_id), .in_reloc(reloc_base),
    .s_valid(s_valid), .s_ea(s_ea), .s_fetch(s_fetch),
    .s_hv(s_hv), .s_real(s_real),
    .s_part(s_part), .s_proc(s_proc), .s_reloc(s_reloc)
  );

  logic            qm_fault;
  logic [ID_W-1:0] qm_part, qm_proc;

  ctx_quadrant_map #(.ID_W(ID_W), .SEG_BITS(SEG_BITS)) u_qmap (
    .quad(s_ea[QUAD_HI -: 2]),
    .rsvd_field(s_ea[RSVD_HI -: SEG_BITS]),
    .hv(s_hv),
    .cur_part(s_part), .cur_proc(s_proc),
    .fault(qm_fault), .part_out(qm_part), .proc_out(qm_proc)
  );

  logic [EA_W-1:0] rx_addr;

  ctx_real_xlate #(.EA_W(EA_W), .TOP_CLR(TOP_CLR)) u_real (
    .ea(s_ea), .reloc(s_reloc), .raddr(rx_addr)
  );

  outcome_t nxt;
  logic     bypass;

  always_comb begin
    bypass       = s_hv & s_real;
    nxt.real_ok  = bypass;
    nxt.ctx_ok   = ~bypass & ~qm_fault;
    nxt.seg_inst = ~bypass & qm_fault & s_fetch;
    nxt.seg_data = ~bypass & qm_fault & ~s_fetch;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done           <= 1'b0;
      ctx_ok         <= 1'b0;
      real_ok        <= 1'b0;
      seg_fault_inst <= 1'b0;
      seg_fault_data <= 1'b0;
      part_id        <= '0;
      proc_id        <= '0;
      real_addr      <= '0;
      perm           <= PERM_NONE;
      page_bits      <= '0;
      fault_addr     <= '0;
    end else begin
      done <= s_valid;
      if (s_valid) begin
        ctx_ok         <= nxt.ctx_ok;
        real_ok        <= nxt.real_ok;
        seg_fault_inst <= nxt.seg_inst;
        seg_fault_data <= nxt.seg_data;
        part_id        <= nxt.ctx_ok ? qm_part : '0;
        proc_id        <= nxt.ctx_ok ? qm_proc : '0;
        real_addr      <= nxt.real_ok ? rx_addr : '0;
        perm           <= nxt.real_ok ? PERM_ALL : PERM_NONE;
        page_bits      <= nxt.real_ok ? MIN_PG : '0;
        if (nxt.seg_data) begin
          fault_addr <= s_ea;
        end
      end
    end
  end
endmodule

// File: rtl/ctx_qualifier_chk.sv
module ctx_qualifier_chk #(
  parameter int EA_W     = 64,
  parameter int ID_W     = 32,
  parameter int TOP_CLR  = 4,
  parameter int SEG_BITS = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [EA_W-1:0] req_ea,
  input logic            hv_mode,
  input logic            real_mode,
  input logic            done,
  input logic            ctx_ok,
  input logic            real_ok,
  input logic            seg_fault_inst,
  input logic            seg_fault_data,
  input logic [ID_W-1:0] part_id,
  input logic [ID_W-1:0] proc_id,
  input logic [EA_W-1:0] real_addr,
  input logic [2:0]      perm,
  input logic [EA_W-1:0] fault_addr
);
  logic            v1, v2;
  logic [EA_W-1:0] ea1, ea2;
  logic            hv1, hv2, rm1, rm2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0;
      ea1 <= '0; ea2 <= '0;
      hv1 <= 1'b0; hv2 <= 1'b0; rm1 <= 1'b0; rm2 <= 1'b0;
    end else begin
      v1 <= req_valid; v2 <= v1;
      ea1 <= req_ea; ea2 <= ea1;
      hv1 <= hv_mode; hv2 <= hv1;
      rm1 <= real_mode; rm2 <= rm1;
    end
  end

  AST_DONE_LAG: assert property (@(posedge clk) disable iff (rst) done == v2); // R1
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    done |-> $countones({ctx_ok, real_ok, seg_fault_inst, seg_fault_data}) == 1); // R6
  AST_RSVD_FAULT: assert property (@(posedge clk) disable iff (rst)
    (done && !(hv2 && rm2) && (ea2[EA_W-3 -: SEG_BITS] != '0)) |-> (seg_fault_inst || seg_fault_data)); // R2
  AST_GUEST_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    (done && !hv2 && (ea2[EA_W-1] != ea2[EA_W-2])) |-> !ctx_ok); // R5
  AST_DATA_ADDR: assert property (@(posedge clk) disable iff (rst)
    (done && seg_fault_data) |-> fault_addr == ea2); // R6
  AST_REAL_RIGHTS: assert property (@(posedge clk) disable iff (rst)
    (done && real_ok) |-> (perm == 3'b111 && real_addr[EA_W-1 -: TOP_CLR] == '0)); // R8
  AST_REAL_ONLY_HV: assert property (@(posedge clk) disable iff (rst)
    (done && real_ok) |-> (hv2 && rm2)); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(part_id) && $stable(proc_id) && $stable(real_addr) && $stable(ctx_ok))); // R10
  AST_FAULT_ADDR_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(done && seg_fault_data) |-> $stable(fault_addr)); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!done && !seg_fault_inst && !seg_fault_data && fault_addr == '0)); // R11
endmodule

bind ctx_qualifier ctx_qualifier_chk #(
  .EA_W(EA_W), .ID_W(ID_W), .TOP_CLR(TOP_CLR), .SEG_BITS(SEG_BITS)
) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ea(req_ea),
  .hv_mode(hv_mode), .real_mode(real_mode), .done(done), .ctx_ok(ctx_ok),
  .real_ok(real_ok), .seg_fault_inst(seg_fault_inst), .seg_fault_data(seg_fault_data),
  .part_id(part_id), .proc_id(proc_id), .real_addr(real_addr), .perm(perm),
  .fault_addr(fault_addr)
);

// File: tb/ctx_qualifier_tb_top.sv
module ctx_qualifier_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] req_ea = '0;
  logic [1:0]  req_kind = 2'b00;
  logic        hv_mode = 1'b0, real_mode = 1'b0;
  logic [31:0] cur_part_id = 32'h0000_0A5A, cur_proc_id = 32'h0000_3C3C;
  logic [63:0] reloc_base = 64'h0000_0000_4000_0000;

  logic        done, ctx_ok, real_ok, seg_fault_inst, seg_fault_data;
  logic [31:0] part_id, proc_id;
  logic [63:0] real_addr, fault_addr;
  logic [2:0]  perm;
  logic [6:0]  page_bits;

  int checks = 0;
  int errors = 0;
  int cycle  = 0;
  string cur_tag = "R11 reset";

  always #5 clk = ~clk;

  ctx_qualifier dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ea(req_ea), .req_kind(req_kind),
    .hv_mode(hv_mode), .real_mode(real_mode), .cur_part_id(cur_part_id),
    .cur_proc_id(cur_proc_id), .reloc_base(reloc_base), .done(done), .ctx_ok(ctx_ok),
    .real_ok(real_ok), .seg_fault_inst(seg_fault_inst), .seg_fault_data(seg_fault_data),
    .part_id(part_id), .proc_id(proc_id), .real_addr(real_addr), .perm(perm),
    .page_bits(page_bits), .fault_addr(fault_addr)
  );

  // Reference model: a two-entry queue of captured requests and expected outputs
  typedef struct {
    logic        v;
    logic [63:0] ea;
    logic [1:0]  kind;
    logic        hv, rm;
    logic [31:0] part, proc;
    logic [63:0] reloc;
  } req_t;

  req_t        pend;
  logic        e_done, e_ctx, e_real, e_si, e_sd;
  logic [31:0] e_part, e_proc;
  logic [63:0] e_raddr, e_fa;
  logic [2:0]  e_perm;
  logic [6:0]  e_pg;

  always @(posedge clk) begin
    cycle <= cycle + 1;
    if (rst) begin
      pend.v <= 1'b0;
      e_done <= 0; e_ctx <= 0; e_real <= 0; e_si <= 0; e_sd <= 0;
      e_part <= 0; e_proc <= 0; e_raddr <= 0; e_fa <= 0; e_perm <= 0; e_pg <= 0;
    end else begin
      pend <= '{req_valid, req_ea, req_kind, hv_mode, real_mode, cur_part_id, cur_proc_id, reloc_base};
      e_done <= pend.v;
      if (pend.v) begin : model
        int q;
        bit fault, fetch;
        q = int'(pend.ea[63:62]);
        fetch = (pend.kind == 2'b10);
        e_part <= 0; e_proc <= 0; e_raddr <= 0; e_perm <= 0; e_pg <= 0;
        e_ctx <= 0; e_real <= 0; e_si <= 0; e_sd <= 0;
        if (pend.hv && pend.rm) begin
          e_real <= 1;
          e_raddr <= (pend.ea & 64'h0FFF_FFFF_FFFF_FFFF) | (pend.ea[63] ? 64'd0 : pend.reloc);
          e_perm <= 3'b111;
          e_pg <= 7'd12;
        end else begin
          fault = (pend.ea[61:52] != 0);
          if (!pend.hv && (q == 1 || q == 2)) fault = 1;
          if (fault) begin
            if (fetch) e_si <= 1;
            else begin e_sd <= 1; e_fa <= pend.ea; end
          end else begin
            e_ctx <= 1;
            if (pend.hv) begin
              e_part <= (q == 1 || q == 2) ? pend.part : 32'd0;
              e_proc <= (q == 0 || q == 1) ? pend.proc : 32'd0;
            end else begin
              e_part <= pend.part;
              e_proc <= (q == 0) ? pend.proc : 32'd0;
            end
          end
        end
      end
    end
  end

  task automatic chk(input string field, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual=%h expected=%h", cur_tag, field, cycle, act, exp);
    end
  endtask

  // Compared on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (cycle > 0) begin
      chk("done(R1)", 64'(done), 64'(e_done));
      chk("ctx_ok(R2)", 64'(ctx_ok), 64'(e_ctx));
      chk("real_ok(R7)", 64'(real_ok), 64'(e_real));
      chk("seg_fault_inst(R6)", 64'(seg_fault_inst), 64'(e_si));
      chk("seg_fault_data(R6)", 64'(seg_fault_data), 64'(e_sd));
      chk("part_id(R3)", 64'(part_id), 64'(e_part));
      chk("proc_id(R3)", 64'(proc_id), 64'(e_proc));
      chk("real_addr(R7)", real_addr, e_raddr);
      chk("perm(R8)", 64'(perm), 64'(e_perm));
      chk("page_bits(R8)", 64'(page_bits), 64'(e_pg));
      chk("fault_addr(R6)", fault_addr, e_fa);
    end
  end

  task automatic issue(input logic [63:0] ea, input logic [1:0] kind, input logic hv, input logic rm);
    @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_kind = kind; hv_mode = hv; real_mode = rm;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state is all zero
    cur_tag = "R11 reset state";
    chk("done after reset (R11)", 64'(done), 64'd0);
    chk("fault_addr after reset (R11)", fault_addr, 64'd0);
    rst = 1'b0;

    cur_tag = "R3 hv quadrants";
    for (int q = 0; q < 4; q++) issue({q[1:0], 62'h0000_1234_5678}, 2'b00, 1'b1, 1'b0);
    cur_tag = "R4 guest quadrants 0 and 3";
    issue(64'h0000_0000_0000_8000, 2'b00, 1'b0, 1'b0);
    issue(64'hC000_0000_0000_8000, 2'b01, 1'b0, 1'b0);
    cur_tag = "R5 guest illegal quadrants";
    issue(64'h4000_0000_0000_1000, 2'b10, 1'b0, 1'b0);
    issue(64'h8000_0000_0000_2000, 2'b00, 1'b0, 1'b0);
    issue(64'h4000_0000_0000_3000, 2'b01, 1'b0, 1'b0);
    cur_tag = "R2 reserved field";
    issue(64'h0010_0000_0000_0000, 2'b00, 1'b1, 1'b0);
    issue(64'h2000_0000_0000_0000, 2'b10, 1'b1, 1'b0);
    issue(64'hC010_0000_0000_0040, 2'b01, 1'b0, 1'b0);
    issue(64'h0000_0000_0000_0000, 2'b00, 1'b0, 1'b0);
    cur_tag = "R6 kind 11 treated as data";
    issue(64'h8000_0000_0000_0777, 2'b11, 1'b0, 1'b0);
    cur_tag = "R7 hv real mode";
    issue(64'h0123_4567_89AB_CDE0, 2'b10, 1'b1, 1'b1);
    issue(64'hF123_4567_89AB_CDE0, 2'b00, 1'b1, 1'b1);
    issue(64'h3FF0_0000_0000_0100, 2'b01, 1'b1, 1'b1);
    cur_tag = "R9 guest real mode";
    issue(64'h0000_0000_0000_5000, 2'b00, 1'b0, 1'b1);
    issue(64'h4000_0000_0000_5000, 2'b00, 1'b0, 1'b1);

    cur_tag = "R1 back-to-back strobes";
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      req_valid = 1'b1; req_ea = {i[1:0], 62'h55}; req_kind = 2'(i); hv_mode = i[0]; real_mode = 1'b0;
      cur_part_id = 32'h100 + 32'(i);
      @(negedge clk);
    end
    req_valid = 1'b0;
    repeat (3) @(negedge clk);

    cur_tag = "R10 inputs change without strobe";
    req_ea = 64'h4000_0000_0000_0000; hv_mode = 1'b0; cur_proc_id = 32'hDEAD;
    reloc_base = 64'h1; repeat (5) @(negedge clk);

    cur_tag = "R11 reset after data fault";
    issue(64'h0020_0000_0000_0000, 2'b00, 1'b1, 1'b0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule